// File: doc/BRIEF.md
# ADC Serial Result Shifter

This block is the output side of a serial analog-to-digital converter port. It runs from the external serial clock and shifts out one conversion frame while the active-low chip select is held low. A frame carries a 14-bit result and 2 status bits, and it begins with a run of zero bits. The frame is arranged so that a host that moves data in whole bytes reads it as three bytes: the first byte is all zeros, and the result and status bits fill the second and third bytes.

The result and status inputs are captured at the moment chip select goes low, so the parallel inputs can change while a frame is in flight. The output is meant for a serial clock that idles low and a host that samples on the rising edge. The block moves to the next bit on each falling edge. The first bit is presented as soon as the block is selected. When chip select is high, the block clears its bit position at once and releases the line through its output-enable port. The block can serve as the device under test for a host controller, or as a synthesizable model of the converter.

Top module: `adc_frame_shifter`

## Requirements
- R1: `sdoOe` is 1 whenever `csN` is 0 and 0 whenever `csN` is 1, so the pad is released while the block is deselected.
- R2: `sdoData` changes only on a falling edge of `sclk` or a change of `csN`, so it stays stable from each rising edge to the next falling edge.
- R3: Frame positions 0 to 7 are 0. Position 0 is valid as soon as `csN` falls, before any `sclk` edge. Position k is the bit present after k falling edges.
- R4: Frame positions 8 to 21 carry `resultIn[13]` down to `resultIn[0]`, most significant bit first.
- R5: Frame position 22 carries `statusIn[1]` and position 23 carries `statusIn[0]`.
- R6: `resultIn` and `statusIn` are captured on the falling edge of `csN`. Later changes to them have no effect on the frame in flight.
- R7: After 24 falling edges of `sclk`, `sdoData` stays 0 for any further clocks until `csN` rises.
- R8: A rise of `csN` part-way through a frame clears the bit position at once. The next selection starts again at position 0 with a fresh capture of the inputs.
- R9: While `csN` is 1, `sdoData` is 0, and toggling `sclk` has no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host; idles low |
| csN | input | 1 | Active-low chip select; when high it clears the bit position asynchronously |
| resultIn | input | 14 | Parallel conversion result |
| statusIn | input | 2 | Parallel status bits sent after the result |
| sdoData | output | 1 | Serial data value for the pad |
| sdoOe | output | 1 | Pad output enable; 0 releases the line |

## Verification
Two events can fall in the same cycle: the capture of the parallel inputs, and a change of those inputs. The bench provokes this by changing `resultIn` and `statusIn` in the middle of a frame, and also by raising `csN` part-way through a frame and lowering it again with new values. The bench judges each frame bit by bit against a model that holds the values present at the `csN` fall, sampling each bit mid-high phase and again just before the falling edge. The aborted case passes only if the next frame restarts with zeros and carries the new values.

// File: rtl/adc_shift_pkg.sv
package adc_shift_pkg;

  localparam int PRE_BITS_DEF  = 8;
  localparam int RES_BITS_DEF  = 14;
  localparam int STAT_BITS_DEF = 2;

  // Strobes from the bit sequencer to the data path.
  typedef struct packed {
    logic drive;      // line is owned by this block
    logic inPayload;  // current position is a result or status bit
  } shiftStrobes_t;

endpackage

// File: rtl/adc_shift_ctrl.sv
module adc_shift_ctrl
  import adc_shift_pkg::*;
#(
  parameter int PRE_BITS  = PRE_BITS_DEF,
  parameter int PAY_BITS  = RES_BITS_DEF + STAT_BITS_DEF,
  parameter int FRAME_LEN = PRE_BITS + PAY_BITS,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1),
  parameter int IDX_W     = $clog2(PAY_BITS)
) (
  input  logic             sclk,
  input  logic             csN,
  output shiftStrobes_t    strobes,
  output logic [IDX_W-1:0] payIdx
);

  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] PRE_POS   = CNT_W'(PRE_BITS);
  localparam logic [CNT_W-1:0] PAY_COUNT = CNT_W'(PAY_BITS);

  logic [CNT_W-1:0] bitPos;
  logic [CNT_W-1:0] payOffs;

  // Bit position advances on each falling edge and saturates at the frame end.
  always_ff @(negedge sclk or posedge csN) begin
    if (csN) begin
      bitPos <= '0;
    end else if (bitPos != LAST_POS) begin
      bitPos <= bitPos + 1'b1;
    end
  end

  assign payOffs           = bitPos - PRE_POS;
  assign strobes.drive     = ~csN;
  assign strobes.inPayload = (bitPos >= PRE_POS) && (payOffs < PAY_COUNT);
  assign payIdx            = payOffs[IDX_W-1:0];

endmodule

// File: rtl/adc_shift_dp.sv
module adc_shift_dp
  import adc_shift_pkg::*;
#(
  parameter int RES_BITS  = RES_BITS_DEF,
  parameter int STAT_BITS = STAT_BITS_DEF,
  parameter int PAY_BITS  = RES_BITS + STAT_BITS,
  parameter int IDX_W     = $clog2(PAY_BITS)
) (
  input  logic                 csN,
  input  logic [RES_BITS-1:0]  resultIn,
  input  logic [STAT_BITS-1:0] statusIn,
  input  shiftStrobes_t        strobes,
  input  logic [IDX_W-1:0]     payIdx,
  output logic                 sdoData
);

  logic [PAY_BITS-1:0] payWord;
  logic [PAY_BITS-1:0] sendOrder;
  logic [PAY_BITS-1:0] holdReg;

  assign payWord = {resultIn, statusIn};

  // Reverse once at capture so the payload index counts in send order.
  for (genvar g = 0; g < PAY_BITS; g++) begin : g_order
    assign sendOrder[g] = payWord[PAY_BITS-1-g];
  end

  always_ff @(negedge csN) begin
    holdReg <= sendOrder;
  end

  assign sdoData = strobes.drive & strobes.inPayload & holdReg[payIdx];

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
  import adc_shift_pkg::*;
#(
  parameter int PRE_BITS  = PRE_BITS_DEF,
  parameter int RES_BITS  = RES_BITS_DEF,
  parameter int STAT_BITS = STAT_BITS_DEF
) (
  input  logic                 sclk,
  input  logic                 csN,
  input  logic [RES_BITS-1:0]  resultIn,
  input  logic [STAT_BITS-1:0] statusIn,
  output logic                 sdoData,
  output logic                 sdoOe
);

  localparam int PAY_BITS  = RES_BITS + STAT_BITS;
  localparam int FRAME_LEN = PRE_BITS + PAY_BITS;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IDX_W     = $clog2(PAY_BITS);

  shiftStrobes_t    strobes;
  logic [IDX_W-1:0] payIdx;

  adc_shift_ctrl #(
    .PRE_BITS (PRE_BITS),
    .PAY_BITS (PAY_BITS),
    .FRAME_LEN(FRAME_LEN),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .sclk   (sclk),
    .csN    (csN),
    .strobes(strobes),
    .payIdx (payIdx)
  );

  adc_shift_dp #(
    .RES_BITS (RES_BITS),
    .STAT_BITS(STAT_BITS),
    .PAY_BITS (PAY_BITS),
    .IDX_W    (IDX_W)
  ) u_dp (
    .csN     (csN),
    .resultIn(resultIn),
    .statusIn(statusIn),
    .strobes (strobes),
    .payIdx  (payIdx),
    .sdoData (sdoData)
  );

  assign sdoOe = strobes.drive;

endmodule

// File: rtl/adc_frame_shifter_chk.sv
module adc_frame_shifter_chk #(
  parameter int PRE_BITS  = 8,
  parameter int RES_BITS  = 14,
  parameter int STAT_BITS = 2
) (
  input logic                 sclk,
  input logic                 csN,
  input logic [RES_BITS-1:0]  resultIn,
  input logic [STAT_BITS-1:0] statusIn,
  input logic                 sdoData,
  input logic                 sdoOe
);

  localparam int FRAME_LEN = PRE_BITS + RES_BITS + STAT_BITS;

  logic [5:0]                 riseCnt;
  logic [RES_BITS-1:0]        resSeen;
  logic [STAT_BITS-1:0]       statSeen;
  logic [FRAME_LEN-1:0]       frameModel;
  logic                       modelBit;

  // Rising edges seen since selection: the host reads position riseCnt here.
  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      riseCnt <= '0;
    end else if (riseCnt != 6'h3f) begin
      riseCnt <= riseCnt + 1'b1;
    end
  end

  always_ff @(negedge csN) begin
    resSeen  <= resultIn;
    statSeen <= statusIn;
  end

  assign frameModel = {{PRE_BITS{1'b0}}, resSeen, statSeen};

  always_comb begin
    modelBit = 1'b0;
    for (int i = 0; i < FRAME_LEN; i++) begin
      if (int'(riseCnt) == i) modelBit = frameModel[FRAME_LEN-1-i];
    end
  end

  AST_OE_SELECTED: assert property (@(posedge sclk) disable iff (csN)
    sdoOe) else $error("oe low while selected"); // R1

  always @(posedge sclk) begin
    if (csN) begin
      AST_DESELECT_RELEASED: assert (!sdoOe && !sdoData) else $error("line not released"); // R9
    end
  end

  AST_PREAMBLE_ZERO: assert property (@(posedge sclk) disable iff (csN)
    (int'(riseCnt) < PRE_BITS) |-> !sdoData) else $error("preamble bit set"); // R3

  AST_RESULT_BITS: assert property (@(posedge sclk) disable iff (csN)
    ((int'(riseCnt) >= PRE_BITS) && (int'(riseCnt) < PRE_BITS + RES_BITS))
      |-> (sdoData == modelBit)) else $error("result bit wrong"); // R4

  AST_STATUS_BITS: assert property (@(posedge sclk) disable iff (csN)
    ((int'(riseCnt) >= PRE_BITS + RES_BITS) && (int'(riseCnt) < FRAME_LEN))
      |-> (sdoData == modelBit)) else $error("status bit wrong"); // R5

  AST_TAIL_ZERO: assert property (@(posedge sclk) disable iff (csN)
    (int'(riseCnt) >= FRAME_LEN) |-> !sdoData) else $error("tail bit set"); // R7

endmodule

bind adc_frame_shifter adc_frame_shifter_chk #(
  .PRE_BITS (PRE_BITS),
  .RES_BITS (RES_BITS),
  .STAT_BITS(STAT_BITS)
) u_chk (
  .sclk    (sclk),
  .csN     (csN),
  .resultIn(resultIn),
  .statusIn(statusIn),
  .sdoData (sdoData),
  .sdoOe   (sdoOe)
);

// File: tb/adc_frame_shifter_tb.sv
`timescale 1ns/1ps
module adc_frame_shifter_tb;

  logic        sclk;
  logic        csN;
  logic [13:0] resultIn;
  logic [1:0]  statusIn;
  logic        sdoData;
  logic        sdoOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  adc_frame_shifter u_dut (
    .sclk    (sclk),
    .csN     (csN),
    .resultIn(resultIn),
    .statusIn(statusIn),
    .sdoData (sdoData),
    .sdoOe   (sdoOe)
  );

  function automatic logic expBit(logic [13:0] r, logic [1:0] s, int pos);
    if (pos < 8)  return 1'b0;
    if (pos < 22) return r[21-pos];
    if (pos < 24) return s[23-pos];
    return 1'b0;
  endfunction

  function automatic string reqOf(int pos);
    if (pos < 8)  return "R3";
    if (pos < 22) return "R4";
    if (pos < 24) return "R5";
    return "R7";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One frame of nClk serial clocks at 50 MHz (20 ns period).
  // midChange: alter the parallel inputs after clock 10 (R6).
  task automatic runFrame(logic [13:0] r, logic [1:0] s, int nClk, bit midChange);
    resultIn = r;
    statusIn = s;
    #5 csN = 0;
    #2;
    check(sdoOe == 1'b1, "R1", int'(sdoOe), 1);
    check(sdoData == 1'b0, "R3", int'(sdoData), 0);
    #3;
    for (int i = 0; i < nClk; i++) begin
      logic s1, s2;
      sclk = 1;
      #5 s1 = sdoData;
      #4 s2 = sdoData;
      check(s1 == expBit(r, s, i), reqOf(i), int'(s1), int'(expBit(r, s, i)));
      check(s1 == s2, "R2", int'(s2), int'(s1));
      if (midChange && i == 10) begin
        resultIn = ~r;
        statusIn = ~s;
        check(s2 == expBit(r, s, i), "R6", int'(s2), int'(expBit(r, s, i)));
      end
      #1 sclk = 0;
      #10;
    end
    csN = 1;
    #5;
    check(sdoOe == 1'b0, "R1", int'(sdoOe), 0);
    check(sdoData == 1'b0, "R9", int'(sdoData), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    sclk = 0;
    csN = 1;
    resultIn = '0;
    statusIn = '0;
    #7;
    check(sdoOe == 1'b0, "R1", int'(sdoOe), 0);
    check(sdoData == 1'b0, "R9", int'(sdoData), 0);

    // Directed corner cases.
    runFrame(14'h3fff, 2'b11, 24, 0);       // R4 R5 all ones
    runFrame(14'h0000, 2'b00, 24, 0);
    runFrame(14'h2aaa, 2'b10, 24, 0);
    runFrame(14'h1555, 2'b01, 30, 0);       // R7 extra clocks after frame end
    runFrame(14'h2c3a, 2'b10, 24, 1);       // R6 inputs change mid-frame
    runFrame(14'h3fff, 2'b11, 12, 0);       // R8 aborted in result field
    runFrame(14'h0f0f, 2'b01, 24, 0);       // R8 restart from position 0

    // R9: clocks while deselected must not advance anything.
    for (int k = 0; k < 3; k++) begin
      sclk = 1;
      #5 check(sdoOe == 1'b0 && sdoData == 1'b0, "R9", int'({sdoOe, sdoData}), 0);
      #5 sclk = 0;
      #10;
    end
    runFrame(14'h2001, 2'b10, 24, 0);       // R9 next frame starts clean

    // Random frames.
    for (int n = 0; n < 40; n++) begin
      logic [13:0] r;
      logic [1:0]  s;
      int          len;
      r   = 14'($urandom);
      s   = 2'($urandom);
      len = 4 + int'($urandom % 28);
      runFrame(r, s, len, ($urandom % 3) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule